// File: doc/BRIEF.md
# Four-Mode Register with Ripple Increment

This block is a small synchronous register whose next contents are chosen, on every rising clock edge, by a two-bit mode input. Three modes are fixed: capture a parallel word, fill every bit with 1, or move the contents one place toward bit 0 while a serial bit enters at the top. The fourth mode is set when the block is built. In the counting variant it adds one to the register through a bit-serial carry chain. In the holding variant it keeps the contents as they are.

Each bit position is a flip-flop fed by its own four-way selector, and all selectors share the mode input. In the counting variant the last link of the carry chain is brought out as a combinational carry. That carry tells a downstream stage that the register will wrap on the next edge, so several of these registers can be chained into a wider counter.

Top module: `qmode_reg`

## Requirements
- R1: While `rst` is 1 at a rising edge, `dataOut` becomes 0000 on that edge, whatever `modeSel` and the data inputs are.
- R2: With `modeSel` = 00 (parallel capture), `dataOut` takes the value of `parIn` on the edge.
- R3: With `modeSel` = 01 (fill), `dataOut` becomes 1111 on the edge.
- R4: With `modeSel` = 10 (move toward bit 0), new bit i equals old bit i+1, new bit 3 equals `serIn`, and the old bit 0 is lost.
- R5: In the counting variant (`COUNT_EN` = 1), `modeSel` = 11 sets `dataOut` to the old value plus one, modulo 16.
- R6: In the counting variant, `carryOut` is 1 exactly when `modeSel` = 11, `rst` = 0 and `dataOut` = 1111, in the same cycle with no register delay. The following edge then gives `dataOut` = 0000.
- R7: In the holding variant (`COUNT_EN` = 0), `modeSel` = 11 leaves `dataOut` unchanged and `carryOut` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear, overrides every mode |
| modeSel | input | 2 | Mode: 00 capture, 01 fill, 10 move down, 11 count or hold |
| parIn | input | 4 | Parallel data word for capture mode |
| serIn | input | 1 | Bit entering the top position in move-down mode |
| dataOut | output | 4 | Register contents |
| carryOut | output | 1 | Combinational carry out of the last increment stage |

## Verification
The bench builds two copies at the default width of four bits, one with `COUNT_EN` = 1 and one with `COUNT_EN` = 0, and drives both with the same stimulus. Four bits make the full product small: each of the 16 start values meets each of the 4 modes, each of the 16 parallel words and both serial bits. This covers the wrap from 1111 to 0000, the carry at that one state only, and the single mode in which the two variants differ. Reset is also checked while the fill mode is selected, to show that it takes priority.

// File: rtl/qmr_pkg.sv
package qmr_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD  = 2'b00,
    MODE_ONES  = 2'b01,
    MODE_SHIFT = 2'b10,
    MODE_AUX   = 2'b11
  } mode_e;

  typedef struct packed {
    logic  clear;
    mode_e sel;
    logic  incr;
  } strobe_t;
endpackage

// File: rtl/qmr_ctrl.sv
module qmr_ctrl
  import qmr_pkg::*;
#(
  parameter bit COUNT_EN = 1'b1
) (
  input  logic       rst,
  input  logic [1:0] modeSel,
  output strobe_t    strb
);
  mode_e modeDec;

  always_comb begin
    modeDec    = mode_e'(modeSel);
    strb.clear = rst;
    strb.sel   = modeDec;
    strb.incr  = COUNT_EN && !rst && (modeDec == MODE_AUX);
  end
endmodule

// File: rtl/qmr_datapath.sv
module qmr_datapath
  import qmr_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter bit COUNT_EN = 1'b1
) (
  input  logic             clk,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic [WIDTH-1:0] q,
  output logic             carryOut
);
  localparam int CHAIN = WIDTH + 1;

  logic [CHAIN-1:0] carry;
  logic [WIDTH-1:0] dNext;

  assign carry[0] = strb.incr;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic downSrc;
    logic auxSrc;

    if (i == WIDTH - 1) begin : g_top
      assign downSrc = serIn;
    end else begin : g_mid
      assign downSrc = q[i+1];
    end

    if (COUNT_EN) begin : g_cnt
      assign auxSrc     = q[i] ^ carry[i];
      assign carry[i+1] = q[i] & carry[i];
    end else begin : g_hold
      assign auxSrc     = q[i];
      assign carry[i+1] = 1'b0;
    end

    always_comb begin
      unique case (strb.sel)
        MODE_LOAD:  dNext[i] = parIn[i];
        MODE_ONES:  dNext[i] = 1'b1;
        MODE_SHIFT: dNext[i] = downSrc;
        default:    dNext[i] = auxSrc;
      endcase
    end

    always_ff @(posedge clk) begin
      if (strb.clear) q[i] <= 1'b0;
      else            q[i] <= dNext[i];
    end
  end

  assign carryOut = carry[WIDTH];

  assert_clear_R1: assert property (@(posedge clk)
    strb.clear |=> (q == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.sel == MODE_LOAD) |=> (q == $past(parIn)));

  assert_ones_R3: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.sel == MODE_ONES) |=> (q == '1));

  assert_shift_R4: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.sel == MODE_SHIFT) |=> (q == {$past(serIn), $past(q[WIDTH-1:1])}));

  if (COUNT_EN) begin : g_cnt_chk
    assert_count_R5: assert property (@(posedge clk) disable iff (strb.clear)
      (strb.sel == MODE_AUX) |=> (q == WIDTH'($past(q) + 1'b1)));
    assert_carry_wrap_R6: assert property (@(posedge clk) disable iff (strb.clear)
      carryOut |=> (q == '0));
    assert_carry_full_R6: assert property (@(posedge clk) disable iff (strb.clear)
      carryOut |-> ((q == '1) && (strb.sel == MODE_AUX)));
  end else begin : g_hold_chk
    assert_hold_R7: assert property (@(posedge clk) disable iff (strb.clear)
      (strb.sel == MODE_AUX) |=> $stable(q));
    assert_nocarry_R7: assert property (@(posedge clk) disable iff (strb.clear)
      !carryOut);
  end
endmodule

// File: rtl/qmode_reg.sv
module qmode_reg
  import qmr_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter bit COUNT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       modeSel,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             carryOut
);
  strobe_t strb;

  qmr_ctrl #(.COUNT_EN(COUNT_EN)) u_ctrl (
    .rst     (rst),
    .modeSel (modeSel),
    .strb    (strb)
  );

  qmr_datapath #(.WIDTH(WIDTH), .COUNT_EN(COUNT_EN)) u_dp (
    .clk      (clk),
    .strb     (strb),
    .parIn    (parIn),
    .serIn    (serIn),
    .q        (dataOut),
    .carryOut (carryOut)
  );
endmodule

// File: tb/qmode_reg_bench.sv
module qmode_reg_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] modeSel = 2'b00;
  logic [3:0] parIn = 4'h0;
  logic       serIn = 1'b0;
  logic [3:0] outCnt, outHold;
  logic       cyCnt, cyHold;
  int         tests = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  qmode_reg #(.WIDTH(4), .COUNT_EN(1'b1)) u_qmode_reg (
    .clk(clk), .rst(rst), .modeSel(modeSel), .parIn(parIn), .serIn(serIn),
    .dataOut(outCnt), .carryOut(cyCnt));

  qmode_reg #(.WIDTH(4), .COUNT_EN(1'b0)) u_qmode_reg_hold (
    .clk(clk), .rst(rst), .modeSel(modeSel), .parIn(parIn), .serIn(serIn),
    .dataOut(outHold), .carryOut(cyHold));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expect_next(input logic [1:0] m, input logic [3:0] s,
                                             input logic [3:0] p, input logic sb,
                                             input bit cnt);
    case (m)
      2'b00:   return p;
      2'b01:   return 4'hF;
      2'b10:   return {sb, s[3:1]};
      default: return cnt ? 4'((s + 5'd1) % 16) : s;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    modeSel = 2'b01;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset state counting", {4'h0, outCnt}, 8'h00);
    check("R1 reset state holding", {4'h0, outHold}, 8'h00);
    rst = 1'b0;
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 4; m++) begin
        for (int p = 0; p < 16; p++) begin
          for (int b = 0; b < 2; b++) begin
            modeSel = 2'b00;
            parIn   = 4'(s);
            @(posedge clk);
            @(negedge clk);
            modeSel = 2'(m);
            parIn   = 4'(p);
            serIn   = 1'(b);
            #1;
            check("R6 carry in counting variant", {7'd0, cyCnt},
                  {7'd0, (m == 3) && (s == 15)});
            check("R7 carry in holding variant", {7'd0, cyHold}, 8'h00);
            @(posedge clk);
            @(negedge clk);
            case (m)
              0: check("R2 parallel capture", {4'h0, outCnt},
                       {4'h0, expect_next(2'(m), 4'(s), 4'(p), 1'(b), 1'b1)});
              1: check("R3 fill with ones", {4'h0, outCnt},
                       {4'h0, expect_next(2'(m), 4'(s), 4'(p), 1'(b), 1'b1)});
              2: check("R4 move toward bit 0", {4'h0, outCnt},
                       {4'h0, expect_next(2'(m), 4'(s), 4'(p), 1'(b), 1'b1)});
              default: check("R5 R6 increment and wrap", {4'h0, outCnt},
                       {4'h0, expect_next(2'(m), 4'(s), 4'(p), 1'(b), 1'b1)});
            endcase
            check(m == 3 ? "R7 hold mode" : "R2 R3 R4 holding variant",
                  {4'h0, outHold},
                  {4'h0, expect_next(2'(m), 4'(s), 4'(p), 1'(b), 1'b0)});
          end
        end
      end
    end
    modeSel = 2'b10;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset overrides mode", {outCnt, outHold}, 8'h00);
    rst = 1'b0;
    modeSel = 2'b11;
    @(posedge clk);
    @(negedge clk);
    check("R5 count from zero after reset", {4'h0, outCnt}, 8'h01);
    check("R7 hold at zero after reset", {4'h0, outHold}, 8'h00);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule